// File: doc/BRIEF.md
# Set-Associative Tag Directory with Selectable Replacement

This block is the lookup and bookkeeping half of a set-associative cache. Each request carries an address and a strobe. The block cuts the address into a tag field, a set-selection field and a line-offset field. It then compares the tag against every valid way of the selected set. The outcome is registered and reported on the next cycle: hit or miss, and the way that hit or that received the new tag.

On a miss the tag is installed at once. An empty way is always filled first. When the set is full, a way is evicted under the policy chosen on a run-time pin. One choice evicts the oldest insertion. The other evicts the way touched longest ago.

A free-running miss counter lets a known reference trace be checked against its expected miss total. Line data, write-back and the memory side belong to the surrounding cache. With a single way per set the block behaves as a direct-mapped directory.

Top module: `setassoc_tagdir`

## Requirements
- R1: The tag is `req_addr[ADDR_W-1 : INDEX_W+OFFSET_W]` and the set index is `req_addr[INDEX_W+OFFSET_W-1 : OFFSET_W]`. The low OFFSET_W bits never affect the result. With the defaults (32-bit address, 7 index bits, 5 offset bits) the tag is bits 31..12 and the index is bits 11..5.
- R2: A request hits only when its tag equals the stored tag of a valid way in its own set. Reset invalidates every way, so the first access after reset to any address misses.
- R3: `resp_valid` is `req_valid` delayed by one clock. `resp_hit` and `resp_way` refer to the request of the previous cycle, and `resp_hit` is 0 whenever `resp_valid` is 0. Back-to-back requests each see the state left by the one before.
- R4: `miss_count` grows by exactly one for each response with `resp_hit` = 0 and `resp_valid` = 1. It holds otherwise and is cleared by reset.
- R5: A miss in a set that still has invalid ways installs into the lowest-numbered invalid way, and `resp_way` reports that way.
- R6: With `policy_lru` = 0, a miss in a full set evicts the way installed earliest, and hits leave the order unchanged.
- R7: With `policy_lru` = 1, a miss in a full set evicts the way whose last hit or fill is oldest, and every hit makes its way the most recent.
- R8: With 2 ways and the trace A B C A B C B A B D in one set from cold, the first policy counts 9 misses and the second counts 8.
- R9: With WAYS = 1, every miss replaces way 0 whatever `policy_lru` is, and `resp_way` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy_lru | input | 1 | 0 = evict oldest insertion, 1 = evict least recently used |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| resp_valid | output | 1 | Response present, one cycle after the strobe |
| resp_hit | output | 1 | Request hit a valid way |
| resp_way | output | WAY_W | Way that hit or was filled |
| miss_count | output | CNT_W | Running count of misses |

## Verification
The bench attacks the points where the two policies part ways.

A hit on the older line before a conflict miss makes the insertion-order policy evict that very line. A design that let hits reorder the ways would evict the other one. A design that never refreshed on a hit would fail the least-recently-used trace total of 8 and report 9 instead.

Offset-only changes must hit, and an equal tag in a different set must miss. A swapped field boundary would flip one of those outcomes. Filling the second way of a set exposes a victim picker that ignores the valid bits.

The direct-mapped instance checks that a single-way build always replaces way 0. A miscounted rank width or a policy dependence there would show up as a wrong way or a wrong hit.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
    localparam logic POL_FIFO = 1'b0;
    localparam logic POL_LRU  = 1'b1;

    function automatic int way_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tagdir_split.sv
module tagdir_split #(
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 7,
    parameter int OFFSET_W = 5,
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [TAG_W-1:0]   tag,
    output logic [INDEX_W-1:0] index
);
    assign tag   = addr[ADDR_W-1 -: TAG_W];
    assign index = addr[OFFSET_W +: INDEX_W];
endmodule

// File: rtl/tagdir_lookup.sv
module tagdir_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       line_valid,
    input  logic [WAYS*TAG_W-1:0] line_tags,
    input  logic [TAG_W-1:0]      probe_tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = line_valid[g] && (line_tags[g*TAG_W +: TAG_W] == probe_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       line_valid,
    input  logic [WAYS*WAY_W-1:0] line_rank,
    output logic [WAY_W-1:0]      victim
);
    logic [WAYS-1:0] empty;
    logic [WAYS-1:0] oldest;

    for (genvar g = 0; g < WAYS; g++) begin : g_flags
        assign empty[g]  = !line_valid[g];
        assign oldest[g] = (line_rank[g*WAY_W +: WAY_W] == WAY_W'(WAYS - 1));
    end

    always_comb begin
        victim = '0;
        if (|empty) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (empty[w]) victim = WAY_W'(w);
            end
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (oldest[w]) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/setassoc_tagdir.sv
module setassoc_tagdir
    import tagdir_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int INDEX_W  = 7,
    parameter int OFFSET_W = 5,
    parameter int WAYS     = 4,
    parameter int CNT_W    = 16,
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W,
    localparam int SETS    = 1 << INDEX_W,
    localparam int WAY_W   = way_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              policy_lru,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic [CNT_W-1:0]  miss_count
);
    // rank 0 = most recent; rank WAYS-1 = next to go
    typedef struct {
        logic             valid [SETS][WAYS];
        logic [TAG_W-1:0] tags  [SETS][WAYS];
        logic [WAY_W-1:0] rank  [SETS][WAYS];
        logic             resp_valid;
        logic             resp_hit;
        logic [WAY_W-1:0] resp_way;
        logic [CNT_W-1:0] misses;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]      req_tag;
    logic [INDEX_W-1:0]    req_idx;
    logic [WAYS-1:0]       row_valid;
    logic [WAYS*TAG_W-1:0] row_tags;
    logic [WAYS*WAY_W-1:0] row_rank;
    logic                  lk_hit;
    logic [WAY_W-1:0]      lk_way;
    logic [WAY_W-1:0]      vic_way;
    logic [WAY_W-1:0]      sel_way;
    logic [WAY_W-1:0]      sel_rank;

    tagdir_split #(
        .ADDR_W  (ADDR_W),
        .INDEX_W (INDEX_W),
        .OFFSET_W(OFFSET_W)
    ) u_split (
        .addr (req_addr),
        .tag  (req_tag),
        .index(req_idx)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_valid[w]                 = st_q.valid[req_idx][w];
            row_tags[w*TAG_W +: TAG_W]   = st_q.tags[req_idx][w];
            row_rank[w*WAY_W +: WAY_W]   = st_q.rank[req_idx][w];
        end
    end

    tagdir_lookup #(
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .WAY_W(WAY_W)
    ) u_lookup (
        .line_valid(row_valid),
        .line_tags (row_tags),
        .probe_tag (req_tag),
        .hit       (lk_hit),
        .hit_way   (lk_way)
    );

    tagdir_victim #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) u_victim (
        .line_valid(row_valid),
        .line_rank (row_rank),
        .victim    (vic_way)
    );

    assign sel_way  = lk_hit ? lk_way : vic_way;
    assign sel_rank = st_q.rank[req_idx][sel_way];

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = req_valid;
        st_d.resp_hit   = req_valid && lk_hit;
        st_d.resp_way   = req_valid ? sel_way : '0;

        if (req_valid) begin
            if (!lk_hit) begin
                st_d.valid[req_idx][vic_way] = 1'b1;
                st_d.tags[req_idx][vic_way]  = req_tag;
                st_d.misses                  = st_q.misses + 1'b1;
            end
            // fills always move to the front; hits only under LRU
            if (!lk_hit || (policy_lru == POL_LRU)) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == sel_way) begin
                        st_d.rank[req_idx][w] = '0;
                    end else if (st_q.rank[req_idx][w] < sel_rank) begin
                        st_d.rank[req_idx][w] = st_q.rank[req_idx][w] + 1'b1;
                    end
                end
            end
        end

        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_d.valid[s][w] = 1'b0;
                    st_d.tags[s][w]  = '0;
                    st_d.rank[s][w]  = WAY_W'(WAYS - 1 - w);
                end
            end
            st_d.resp_valid = 1'b0;
            st_d.resp_hit   = 1'b0;
            st_d.resp_way   = '0;
            st_d.misses     = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign resp_valid = st_q.resp_valid;
    assign resp_hit   = st_q.resp_hit;
    assign resp_way   = st_q.resp_way;
    assign miss_count = st_q.misses;
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
    parameter int ADDR_W = 32,
    parameter int WAY_W  = 2,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [WAY_W-1:0]  resp_way,
    input logic [CNT_W-1:0]  miss_count
);
    p_resp_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid && !resp_hit);

    p_miss_counts_r4: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> miss_count == $past(miss_count) + 1'b1);

    p_hit_holds_count_r4: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && !resp_hit) |-> $stable(miss_count));

    p_repeat_hits_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && req_valid && req_addr == $past(req_addr))
        |=> resp_hit && resp_way == $past(resp_way));
endmodule

bind setassoc_tagdir tagdir_chk #(
    .ADDR_W(ADDR_W),
    .WAY_W (WAY_W),
    .CNT_W (CNT_W)
) u_chk (.*);

// File: tb/setassoc_tagdir_test.sv
module setassoc_tagdir_test;
    localparam int CLK_P = 10;

    typedef struct {
        bit    dm;
        bit    hit;
        int    way;
        int    cnt;
        string rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        policy_lru = 1'b0;
    logic        a_valid = 1'b0;
    logic        d_valid = 1'b0;
    logic [15:0] addr = '0;

    logic       a_rv, a_hit, d_rv, d_hit;
    logic [0:0] a_way, d_way;
    logic [7:0] a_cnt, d_cnt;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   a_exp  = 0;
    int   d_exp  = 0;

    always #(CLK_P/2) clk = ~clk;

    setassoc_tagdir #(.ADDR_W(16), .INDEX_W(3), .OFFSET_W(2), .WAYS(2), .CNT_W(8)) uut (
        .clk(clk), .rst(rst), .policy_lru(policy_lru), .req_valid(a_valid), .req_addr(addr),
        .resp_valid(a_rv), .resp_hit(a_hit), .resp_way(a_way), .miss_count(a_cnt));

    setassoc_tagdir #(.ADDR_W(16), .INDEX_W(3), .OFFSET_W(2), .WAYS(1), .CNT_W(8)) uut_dm (
        .clk(clk), .rst(rst), .policy_lru(policy_lru), .req_valid(d_valid), .req_addr(addr),
        .resp_valid(d_rv), .resp_hit(d_hit), .resp_way(d_way), .miss_count(d_cnt));

    task automatic chk(string r, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // driver: tag 11 bits, index 3 bits, offset 2 bits
    task automatic issue(bit dm, int t, int i, int o, bit hit, int way, string rq);
        exp_t e;
        @(negedge clk);
        addr    = {t[10:0], i[2:0], o[1:0]};
        a_valid = !dm;
        d_valid = dm;
        if (!hit) begin
            if (dm) d_exp++; else a_exp++;
        end
        e.dm = dm; e.hit = hit; e.way = way; e.cnt = dm ? d_exp : a_exp; e.rq = rq;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        a_valid = 1'b0;
        d_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R3", int'(a_rv | d_rv), 0, "resp_valid while idle");
            chk("R3", int'(a_hit | d_hit), 0, "resp_hit while idle");
        end
    endtask

    task automatic do_reset();
        idle(2);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4", int'(a_cnt), 0, "miss_count in reset");
        chk("R4", int'(d_cnt), 0, "dm miss_count in reset");
        chk("R3", int'(a_rv), 0, "resp_valid in reset");
        rst   = 1'b0;
        a_exp = 0;
        d_exp = 0;
    endtask

    // monitor: compare each response with the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (a_rv || d_rv)) begin
                if (q.size() == 0) begin
                    chk("R3", 1, 0, "response with nothing pending");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.dm) begin
                        chk(e.rq, int'(d_rv), 1, "dm resp_valid");
                        chk(e.rq, int'(d_hit), int'(e.hit), "dm resp_hit");
                        chk(e.rq, int'(d_way), e.way, "dm resp_way");
                        chk("R4", int'(d_cnt), e.cnt, "dm miss_count");
                    end else begin
                        chk(e.rq, int'(a_rv), 1, "resp_valid");
                        chk(e.rq, int'(a_hit), int'(e.hit), "resp_hit");
                        chk(e.rq, int'(a_way), e.way, "resp_way");
                        chk("R4", int'(a_cnt), e.cnt, "miss_count");
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R4", int'(a_cnt), 0, "miss_count after reset");
        chk("R3", int'(a_rv), 0, "resp_valid after reset");
        rst = 1'b0;

        // R1 / R2 / R5, insertion-order policy
        policy_lru = 1'b0;
        issue(0, 1, 0, 0, 0, 0, "R2");   // cold miss
        issue(0, 1, 0, 3, 1, 0, "R1");   // offset only differs
        issue(0, 1, 1, 0, 0, 0, "R1");   // same tag, other set
        issue(0, 2, 0, 0, 0, 1, "R5");   // lowest invalid way
        issue(0, 2, 0, 1, 1, 1, "R1");
        // R6: hit on oldest does not save it
        issue(0, 1, 0, 0, 1, 0, "R6");
        issue(0, 3, 0, 0, 0, 0, "R6");
        issue(0, 1, 0, 0, 0, 1, "R6");
        issue(0, 3, 0, 0, 1, 0, "R6");
        idle(2);

        do_reset();
        issue(0, 1, 1, 0, 0, 0, "R2");   // was valid before reset

        // R8, insertion-order trace: A=10 B=11 C=12 D=13 in set 2
        issue(0, 10, 2, 0, 0, 0, "R8");
        issue(0, 11, 2, 0, 0, 1, "R8");
        issue(0, 12, 2, 0, 0, 0, "R8");
        issue(0, 10, 2, 0, 0, 1, "R8");
        issue(0, 11, 2, 0, 0, 0, "R8");
        issue(0, 12, 2, 0, 0, 1, "R8");
        issue(0, 11, 2, 0, 1, 0, "R8");
        issue(0, 10, 2, 0, 0, 0, "R8");
        issue(0, 11, 2, 0, 0, 1, "R8");
        issue(0, 13, 2, 0, 0, 0, "R8");
        idle(2);
        chk("R8", int'(a_cnt), 10, "FIFO trace misses plus one");

        do_reset();
        policy_lru = 1'b1;
        issue(0, 10, 2, 0, 0, 0, "R8");
        issue(0, 11, 2, 0, 0, 1, "R8");
        issue(0, 12, 2, 0, 0, 0, "R8");
        issue(0, 10, 2, 0, 0, 1, "R8");
        issue(0, 11, 2, 0, 0, 0, "R8");
        issue(0, 12, 2, 0, 0, 1, "R8");
        issue(0, 11, 2, 0, 1, 0, "R8");
        issue(0, 10, 2, 0, 0, 1, "R8");
        issue(0, 11, 2, 0, 1, 0, "R8");
        issue(0, 13, 2, 0, 0, 1, "R8");
        idle(2);
        chk("R8", int'(a_cnt), 8, "LRU trace misses");

        // R7: a hit refreshes recency
        issue(0, 20, 3, 0, 0, 0, "R7");
        issue(0, 21, 3, 0, 0, 1, "R7");
        issue(0, 20, 3, 0, 1, 0, "R7");
        issue(0, 22, 3, 0, 0, 1, "R7");
        issue(0, 21, 3, 0, 0, 0, "R7");
        issue(0, 22, 3, 2, 1, 1, "R7");
        idle(2);

        // R9: direct-mapped instance under both policies
        issue(1, 1, 0, 0, 0, 0, "R9");
        issue(1, 1, 0, 2, 1, 0, "R9");
        issue(1, 2, 0, 0, 0, 0, "R9");
        issue(1, 1, 0, 0, 0, 0, "R9");
        issue(1, 2, 4, 0, 0, 0, "R9");
        issue(1, 1, 0, 0, 1, 0, "R9");
        idle(1);
        policy_lru = 1'b0;
        issue(1, 2, 0, 0, 0, 0, "R9");
        issue(1, 2, 0, 0, 1, 0, "R9");
        idle(3);

        chk("R3", q.size(), 0, "pending responses at end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule